// File: doc/BRIEF.md
# Instruction Field Decoder

This block takes one 16-bit instruction word and splits it into the control fields that an 8-bit, one-instruction-per-clock processor needs to execute it. It is purely combinational, so the fields are valid in the same cycle as the word that produces them. The execute stage reads them directly.

The high byte always carries the major opcode, the destination register and a conditional-execution flag. The low byte has one of two meanings, chosen by the major opcode. For the two immediate opcodes it is an 8-bit constant. For every other opcode it carries:

- a condition polarity bit,
- an extra-segment select bit,
- a second register index,
- a 3-bit field that holds either a sub-operation code or a third register index.

The block also tells the register file which two registers to read as ALU operands. Three-register add and subtract read the second and third register fields. Two-operand operations read the destination register itself as the first source. The six unassigned major opcodes are flagged as illegal, and the block forces them to decode as a no-operation.

Top module: `instr_field_decoder`

## Requirements
- R1: For every legal major opcode (0..9), `major_o` = instr[15:12], `tgt_reg_o` = instr[11:9] and `cond_en_o` = instr[8].
- R2: For legal non-immediate opcodes, the low byte is decoded as follows, and `imm_o` is 0:
  - `cond_neg_o` = instr[7]
  - `use_es_o` = instr[6]
  - `src_reg_o` = instr[5:3]
  - `aux_o` = instr[2:0]
- R3: For the immediate opcodes 1 (move immediate) and 4 (push immediate), `imm_o` = instr[7:0]. In this case `cond_neg_o`, `use_es_o`, `src_reg_o` and `aux_o` are all 0.
- R4: `imm_valid_o` is 1 exactly when the major opcode is 1 or 4, and 0 for every other opcode.
- R5: For major opcodes 10..15, `illegal_o` is 1 and every other output is 0, which decodes as opcode 0 (no operation). For opcodes 0..9, `illegal_o` is 0.
- R6: For add (7) and subtract (8), `opa_reg_o` = instr[5:3] and `opb_reg_o` = instr[2:0].
- R7: For the other legal non-immediate opcodes (0, 2, 3, 5, 6, 9), `opa_reg_o` = instr[11:9] (the target doubles as a source) and `opb_reg_o` = instr[5:3].
- R8: For immediate opcodes, `opa_reg_o` = instr[11:9] and `opb_reg_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 16 | Instruction word |
| major_o | output | 4 | Major opcode |
| tgt_reg_o | output | 3 | Target register index |
| cond_en_o | output | 1 | Conditional execution enable |
| cond_neg_o | output | 1 | Condition polarity (1 = execute when false) |
| use_es_o | output | 1 | Extra segment select |
| src_reg_o | output | 3 | Second register index |
| aux_o | output | 3 | Sub-operation code or third register |
| imm_o | output | 8 | Immediate byte |
| imm_valid_o | output | 1 | Low byte is an immediate |
| illegal_o | output | 1 | Unassigned major opcode |
| opa_reg_o | output | 3 | First ALU operand register |
| opb_reg_o | output | 3 | Second ALU operand register |

## Verification
The assertions are evaluated whenever the instruction word changes. They check the following relationships:

- the immediate flag appears only on the two immediate opcodes;
- an illegal opcode leaves every field cleared;
- immediate and register-form fields never appear together;
- the second operand of add and subtract is the third-register field.

Only the bench's scenarios can show that each field is taken from the correct bit positions. The same holds for the choice of first operand in two-operand forms and for the handling of each individual unassigned opcode, since these depend on specific bit patterns being compared against expected values.

// File: rtl/instr_field_decoder.sv
module instr_field_decoder #(
  parameter int IW = 16,
  parameter int OPW = 4,
  parameter int RW = 3,
  parameter int LAST_LEGAL = 9
) (
  input  logic [IW-1:0]   instr_i,
  output logic [OPW-1:0]  major_o,
  output logic [RW-1:0]   tgt_reg_o,
  output logic            cond_en_o,
  output logic            cond_neg_o,
  output logic            use_es_o,
  output logic [RW-1:0]   src_reg_o,
  output logic [RW-1:0]   aux_o,
  output logic [IW/2-1:0] imm_o,
  output logic            imm_valid_o,
  output logic            illegal_o,
  output logic [RW-1:0]   opa_reg_o,
  output logic [RW-1:0]   opb_reg_o
);
  localparam int BW = IW / 2;
  localparam logic [OPW-1:0] OP_MOVI = OPW'(1);
  localparam logic [OPW-1:0] OP_PUSHI = OPW'(4);
  localparam logic [OPW-1:0] OP_ADD = OPW'(7);
  localparam logic [OPW-1:0] OP_SUB = OPW'(8);

  logic [OPW-1:0] raw_op;
  logic [BW-1:0]  lo;
  logic           legal, is_imm, is_3reg;

  assign raw_op  = instr_i[IW-1 -: OPW];
  assign lo      = instr_i[BW-1:0];
  assign legal   = int'(raw_op) <= LAST_LEGAL;
  assign is_imm  = legal && (raw_op == OP_MOVI || raw_op == OP_PUSHI);
  assign is_3reg = legal && (raw_op == OP_ADD || raw_op == OP_SUB);

  always_comb begin
    major_o     = '0;
    tgt_reg_o   = '0;
    cond_en_o   = 1'b0;
    cond_neg_o  = 1'b0;
    use_es_o    = 1'b0;
    src_reg_o   = '0;
    aux_o       = '0;
    imm_o       = '0;
    imm_valid_o = 1'b0;
    illegal_o   = !legal;
    opa_reg_o   = '0;
    opb_reg_o   = '0;
    if (legal) begin
      major_o   = raw_op;
      tgt_reg_o = instr_i[IW-OPW-1 -: RW];
      cond_en_o = instr_i[BW];
      opa_reg_o = instr_i[IW-OPW-1 -: RW];
      if (is_imm) begin
        imm_o       = lo;
        imm_valid_o = 1'b1;
      end else begin
        cond_neg_o = lo[BW-1];
        use_es_o   = lo[BW-2];
        src_reg_o  = lo[2*RW-1 -: RW];
        aux_o      = lo[RW-1:0];
        if (is_3reg) begin
          opa_reg_o = lo[2*RW-1 -: RW];
          opb_reg_o = lo[RW-1:0];
        end else begin
          opb_reg_o = lo[2*RW-1 -: RW];
        end
      end
    end
  end

  always_comb begin
    assert_imm_only_two_ops_R4: assert (!imm_valid_o || major_o == OP_MOVI || major_o == OP_PUSHI);
    assert_illegal_clears_R5: assert (!illegal_o || (major_o == '0 && !imm_valid_o && imm_o == '0
                                      && tgt_reg_o == '0 && opa_reg_o == '0 && !cond_en_o));
    assert_imm_no_regfields_R3: assert (!imm_valid_o || (src_reg_o == '0 && aux_o == '0
                                        && !use_es_o && !cond_neg_o && opb_reg_o == '0));
    assert_reg_form_no_imm_R2: assert (imm_valid_o || imm_o == '0);
    assert_three_reg_opb_R6: assert (!(major_o == OP_ADD || major_o == OP_SUB) || illegal_o
                                     || (opb_reg_o == aux_o && opa_reg_o == src_reg_o));
  end
endmodule

// File: tb/instr_field_decoder_tb_top.sv
module instr_field_decoder_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] instr = 16'h0000;
  logic [3:0] major;
  logic [2:0] tgt, src, aux, opa, opb;
  logic cond_en, cond_neg, use_es, imm_valid, illegal;
  logic [7:0] imm;

  int total = 0;
  int bad = 0;

  instr_field_decoder dut_i (
    .instr_i(instr), .major_o(major), .tgt_reg_o(tgt), .cond_en_o(cond_en),
    .cond_neg_o(cond_neg), .use_es_o(use_es), .src_reg_o(src), .aux_o(aux),
    .imm_o(imm), .imm_valid_o(imm_valid), .illegal_o(illegal),
    .opa_reg_o(opa), .opb_reg_o(opb)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s instr=%h actual=%h expected=%h", req, instr, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] w);
    @(negedge clk);
    instr = w;
    #1;
  endtask

  task automatic t_reset_state;
    apply(16'h0000);
    chk("R1 zero word major", 32'(major), 0);
    chk("R5 zero word not illegal", 32'(illegal), 0);
    chk("R4 zero word no imm", 32'(imm_valid), 0);
  endtask

  task automatic t_first_byte;
    for (int op = 0; op <= 9; op++) begin
      logic [15:0] w;
      w = {op[3:0], 3'd5, 1'b1, 8'h3C};
      apply(w);
      chk("R1 major", 32'(major), 32'(op));
      chk("R1 target", 32'(tgt), 5);
      chk("R1 cond", 32'(cond_en), 1);
      chk("R5 legal", 32'(illegal), 0);
    end
    apply({4'd2, 3'd2, 1'b0, 8'h00});
    chk("R1 cond clear", 32'(cond_en), 0);
    chk("R1 target 2", 32'(tgt), 2);
  endtask

  task automatic t_reg_form;
    apply({4'd2, 3'd1, 1'b1, 1'b1, 1'b0, 3'd6, 3'd3});
    chk("R2 neg", 32'(cond_neg), 1);
    chk("R2 es", 32'(use_es), 0);
    chk("R2 src", 32'(src), 6);
    chk("R2 aux", 32'(aux), 3);
    chk("R2 imm zero", 32'(imm), 0);
    apply({4'd6, 3'd0, 1'b0, 1'b0, 1'b1, 3'd1, 3'd7});
    chk("R2 neg clear", 32'(cond_neg), 0);
    chk("R2 es set", 32'(use_es), 1);
    chk("R2 src 1", 32'(src), 1);
    chk("R2 aux 7", 32'(aux), 7);
  endtask

  task automatic t_immediate;
    apply({4'd1, 3'd4, 1'b1, 8'hC5});
    chk("R3 imm value", 32'(imm), 32'hC5);
    chk("R3 no neg", 32'(cond_neg), 0);
    chk("R3 no es", 32'(use_es), 0);
    chk("R3 no src", 32'(src), 0);
    chk("R3 no aux", 32'(aux), 0);
    apply({4'd4, 3'd7, 1'b0, 8'hFF});
    chk("R3 push imm value", 32'(imm), 32'hFF);
    for (int op = 0; op < 16; op++) begin
      apply({op[3:0], 3'd3, 1'b0, 8'hA5});
      chk("R4 imm_valid", 32'(imm_valid), (op == 1 || op == 4) ? 1 : 0);
    end
  endtask

  task automatic t_illegal;
    for (int op = 10; op < 16; op++) begin
      apply({op[3:0], 3'd7, 1'b1, 8'hFF});
      chk("R5 illegal flag", 32'(illegal), 1);
      chk("R5 all fields", {major, tgt, cond_en, cond_neg, use_es, src, aux, imm, imm_valid, opa, opb}, 0);
    end
  endtask

  task automatic t_three_reg;
    apply({4'd7, 3'd1, 1'b0, 2'b00, 3'd2, 3'd5});
    chk("R6 add opa", 32'(opa), 2);
    chk("R6 add opb", 32'(opb), 5);
    apply({4'd8, 3'd6, 1'b1, 2'b11, 3'd4, 3'd0});
    chk("R6 sub opa", 32'(opa), 4);
    chk("R6 sub opb", 32'(opb), 0);
  endtask

  task automatic t_two_reg;
    int ops[6] = '{0, 2, 3, 5, 6, 9};
    foreach (ops[i]) begin
      apply({ops[i][3:0], 3'd6, 1'b0, 2'b01, 3'd3, 3'd1});
      chk("R7 opa is target", 32'(opa), 6);
      chk("R7 opb is src", 32'(opb), 3);
    end
  endtask

  task automatic t_imm_operands;
    apply({4'd1, 3'd5, 1'b0, 8'h3F});
    chk("R8 movi opa", 32'(opa), 5);
    chk("R8 movi opb", 32'(opb), 0);
    apply({4'd4, 3'd2, 1'b1, 8'hFE});
    chk("R8 pushi opa", 32'(opa), 2);
    chk("R8 pushi opb", 32'(opb), 0);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_first_byte();
    t_reg_form();
    t_immediate();
    t_illegal();
    t_three_reg();
    t_two_reg();
    t_imm_operands();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule